// File: doc/BRIEF.md
# External Bus Wait-State Controller

This controller runs the external bus accesses of a simple processor-side master. The master presents a request with these fields:

- direction: read or write;
- space: memory or I/O;
- an address and write data.

It holds the request until it sees a one-cycle completion pulse. While an access is running, the controller drives the following:

- the address, and the write data for writes;
- an active-low read/write line;
- an active-low I/O strobe;
- an active-low wait-window marker.

It stretches every access by a programmed number of software wait states. When that number is two or more, it then lets an external ready line extend the access cycle by cycle.

The external ready pin passes through one input register every cycle. The level that counts for access cycle c is therefore the level the pin had in cycle c-1. The wait-window marker is low from the first software wait state up to the start of the last one. If the marker is wired straight back to the ready pin, the access gains exactly one extra cycle.

An external agent can take the bus with an active-low hold request. The controller grants it only between accesses. While the grant is active, the controller releases the address and data enables, and new requests wait. An active-low output-off input releases the enables of these outputs:

- the control lines;
- the wait-window marker;
- the grant line.

Tri-state pads are modelled as value/enable pairs.

Top module: `ebus_waitctl`

## Requirements
- R1: After reset, rw_n, iostrb_n, msc_n and hold_gnt_n are 1 and req_done is 0.
- R2: An accepted request is one in which req_valid is high in an idle cycle t with hold_req_n high. Access cycle 0 is cycle t+1. With a latched wait count n below 2, req_done is high only in access cycle n, and ext_rdy is ignored.
- R3: With n of 2 or more, req_done is high in the first access cycle c with c >= n in which ext_rdy was high in cycle c-1. In all other access cycles req_done stays low.
- R4: With n of 2 or more, msc_n is 0 in access cycles 1 to n-1 and 1 in every other cycle. With n below 2, msc_n stays 1.
- R5: When msc_n drives ext_rdy and n is 2 or more, req_done comes in access cycle n+1.
- R6: rw_n is 0 and bus_dout_oe is 1 in every cycle of a write access. Otherwise rw_n is 1 and bus_dout_oe is 0. iostrb_n is 0 in every cycle of an I/O access and 1 otherwise. bus_addr shows the request address during the access.
- R7: For a read, rd_data shows the bus_din value of the completion cycle, from the cycle after req_done onward.
- R8: If hold_req_n is low in an idle cycle, hold_gnt_n is 0 from the next cycle on, with bus_addr_oe, bus_dout_oe and ctl_oe at 0. No access starts while the grant is held. If hold_req_n goes low during an access, the grant comes only after req_done, with one idle cycle in between. After hold_req_n rises, the grant drops in the next cycle, and a waiting request starts one cycle later.
- R9: While off_n is 0, ctl_oe, msc_oe and hold_gnt_oe are 0 in the same cycle. While off_n is 1, they are 1.
- R10: The wait count is latched when a request is accepted, so a change to cfg_wait during an access has no effect on that access. A hold request and an access request in the same idle cycle give the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait | input | WSW (3) | Software wait-state count, latched at acceptance |
| req_valid | input | 1 | Request present; held until req_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW (16) | Request address |
| req_wdata | input | DW (16) | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW (16) | Captured read data |
| bus_addr | output | AW (16) | External address value |
| bus_addr_oe | output | 1 | Address output enable |
| bus_dout | output | DW (16) | External write data value |
| bus_dout_oe | output | 1 | Data output enable |
| bus_din | input | DW (16) | External read data |
| ext_rdy | input | 1 | External ready, registered once |
| rw_n | output | 1 | Read/write, 0 = write |
| iostrb_n | output | 1 | I/O strobe, active low |
| ctl_oe | output | 1 | Enable for rw_n and iostrb_n |
| msc_n | output | 1 | Software wait-window marker, active low |
| msc_oe | output | 1 | Enable for msc_n |
| hold_req_n | input | 1 | Bus hold request, active low |
| hold_gnt_n | output | 1 | Hold grant, active low |
| hold_gnt_oe | output | 1 | Enable for hold_gnt_n |
| off_n | input | 1 | Output-off, active low |

## Verification
Two functions can fall in the same cycle:

- **Hold request with an access request in an idle cycle.** The bench asserts both together. It passes only if the grant appears in the next cycle and no completion pulse comes while the grant is held.
- **Hold request with the end of an access.** The bench lowers hold_req_n in the first cycle of a three-wait access. It passes only if the grant stays off through the completion cycle and the idle cycle after it, and comes on in the cycle after that.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_HOLD = 2'd2
  } ebus_state_e;

  // Ready is consulted only from two software wait states upward.
  function automatic bit ws_uses_ready(input int unsigned n);
    return n >= 2;
  endfunction

  // Wait-window marker: access cycles 1 .. n-1 when ready is consulted.
  function automatic bit ws_in_window(input int unsigned n, input int unsigned k);
    return ws_uses_ready(n) && (k >= 1) && (k + 1 <= n);
  endfunction

  // Completion decision for access cycle k with registered ready rdy.
  function automatic bit ws_finish(input int unsigned n, input int unsigned k,
                                   input bit rdy);
    if (k < n) return 1'b0;
    if (!ws_uses_ready(n)) return 1'b1;
    return rdy;
  endfunction

endpackage

// File: rtl/ebus_rdy_sync.sv
module ebus_rdy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_in,
  output logic rdy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b1;
    else        rdy_q <= rdy_in;
  end
endmodule

// File: rtl/ebus_wait_seq.sv
module ebus_wait_seq
  import ebus_pkg::*;
#(
  parameter int WSW = 3,
  parameter int AW  = 16,
  parameter int DW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WSW-1:0]  cfg_wait,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_io,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            rdy_q,
  input  logic            hold_req,
  input  logic [DW-1:0]   bus_din,
  output ebus_state_e     state,
  output logic            cmd_write,
  output logic            cmd_io,
  output logic [AW-1:0]   addr_q,
  output logic [DW-1:0]   wdata_q,
  output logic            done,
  output logic            msc_active,
  output logic [DW-1:0]   rd_data
);
  logic [WSW-1:0] cnt;
  logic [WSW-1:0] wn;
  logic           accept;
  logic           grant_now;

  assign grant_now  = (state == ST_IDLE) && hold_req;
  assign accept     = (state == ST_IDLE) && !hold_req && req_valid;
  assign done       = (state == ST_ACC) && ws_finish(32'(wn), 32'(cnt), rdy_q);
  assign msc_active = (state == ST_ACC) && ws_in_window(32'(wn), 32'(cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wn        <= '0;
      cmd_write <= 1'b0;
      cmd_io    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_data   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (grant_now) begin
            state <= ST_HOLD;
          end else if (accept) begin
            state     <= ST_ACC;
            cnt       <= '0;
            wn        <= cfg_wait;
            cmd_write <= req_write;
            cmd_io    <= req_io;
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
          end
        end
        ST_ACC: begin
          if (done) begin
            state <= ST_IDLE;
            if (!cmd_write) rd_data <= bus_din;
          end else if (cnt != wn) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!hold_req) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: completion never precedes the last software wait state
  a_r3_not_before_waits: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == wn));
  // R2: short accesses end unconditionally after their waits
  a_r2_short_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC && wn < 2 && cnt == wn) |-> done);
  // R8: an access never hands the bus straight to a hold
  a_r8_no_hold_from_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC) |=> (state != ST_HOLD));
  // R8: nothing completes while the bus is granted away
  a_r8_held_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !done);
  // R4: marker window lies inside a long access, before its completion
  a_r4_msc_window: assert property (@(posedge clk) disable iff (!rst_n)
    msc_active |-> (state == ST_ACC && wn >= 2 && !done));
  // R2: after completion the controller is idle
  a_r2_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == ST_IDLE));
endmodule

// File: rtl/ebus_pin_drv.sv
module ebus_pin_drv
  import ebus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  ebus_state_e    state,
  input  logic           cmd_write,
  input  logic           cmd_io,
  input  logic           msc_active,
  input  logic           off_n,
  input  logic [AW-1:0]  addr_q,
  input  logic [DW-1:0]  wdata_q,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_addr_oe,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_dout_oe,
  output logic           rw_n,
  output logic           iostrb_n,
  output logic           ctl_oe,
  output logic           msc_n,
  output logic           msc_oe,
  output logic           hold_gnt_n,
  output logic           hold_gnt_oe
);
  logic in_acc;
  logic held;

  assign in_acc      = (state == ST_ACC);
  assign held        = (state == ST_HOLD);
  assign bus_addr    = addr_q;
  assign bus_dout    = wdata_q;
  assign bus_addr_oe = !held;
  assign bus_dout_oe = in_acc && cmd_write;
  assign rw_n        = !(in_acc && cmd_write);
  assign iostrb_n    = !(in_acc && cmd_io);
  assign ctl_oe      = off_n && !held;
  assign msc_n       = !msc_active;
  assign msc_oe      = off_n;
  assign hold_gnt_n  = !held;
  assign hold_gnt_oe = off_n;

  always_comb begin
    // R6: write direction only together with driven data
    a_r6_rw_with_data: assert (rw_n || bus_dout_oe);
    // R9: output-off releases control, marker and grant enables
    a_r9_off_release: assert (off_n || (!ctl_oe && !msc_oe && !hold_gnt_oe));
    // R8: a granted bus drives neither address nor data
    a_r8_grant_release: assert (hold_gnt_n || (!bus_addr_oe && !bus_dout_oe));
  end
endmodule

// File: rtl/ebus_waitctl.sv
module ebus_waitctl
  import ebus_pkg::*;
#(
  parameter int WSW = 3,
  parameter int AW  = 16,
  parameter int DW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WSW-1:0]  cfg_wait,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_io,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_done,
  output logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_addr_oe,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_dout_oe,
  input  logic [DW-1:0]   bus_din,
  input  logic            ext_rdy,
  output logic            rw_n,
  output logic            iostrb_n,
  output logic            ctl_oe,
  output logic            msc_n,
  output logic            msc_oe,
  input  logic            hold_req_n,
  output logic            hold_gnt_n,
  output logic            hold_gnt_oe,
  input  logic            off_n
);
  ebus_state_e    state;
  logic           rdy_q;
  logic           cmd_write;
  logic           cmd_io;
  logic           msc_active;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;

  ebus_rdy_sync u_rdy (
    .clk(clk), .rst_n(rst_n), .rdy_in(ext_rdy), .rdy_q(rdy_q)
  );

  ebus_wait_seq #(.WSW(WSW), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy_q(rdy_q),
    .hold_req(!hold_req_n), .bus_din(bus_din), .state(state),
    .cmd_write(cmd_write), .cmd_io(cmd_io), .addr_q(addr_q),
    .wdata_q(wdata_q), .done(req_done), .msc_active(msc_active),
    .rd_data(rd_data)
  );

  ebus_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .state(state), .cmd_write(cmd_write), .cmd_io(cmd_io),
    .msc_active(msc_active), .off_n(off_n), .addr_q(addr_q),
    .wdata_q(wdata_q), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .rw_n(rw_n),
    .iostrb_n(iostrb_n), .ctl_oe(ctl_oe), .msc_n(msc_n), .msc_oe(msc_oe),
    .hold_gnt_n(hold_gnt_n), .hold_gnt_oe(hold_gnt_oe)
  );

  // R1: grant and done are inactive out of reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hold_gnt_n && !req_done));
endmodule

// File: tb/ebus_waitctl_tb_top.sv
module ebus_waitctl_tb_top;
  localparam int WSW = 3;
  localparam int AW  = 16;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WSW-1:0] cfg_wait = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic req_done, bus_addr_oe, bus_dout_oe, rw_n, iostrb_n, ctl_oe;
  logic msc_n, msc_oe, hold_gnt_n, hold_gnt_oe;
  logic [DW-1:0] rd_data, bus_dout;
  logic [AW-1:0] bus_addr;
  logic rdy_drv = 1'b1, loop_mode = 1'b0;
  logic hold_req_n = 1'b1, off_n = 1'b1;
  logic ext_rdy;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  assign ext_rdy = loop_mode ? msc_n : rdy_drv;

  always #5 clk = ~clk;

  ebus_waitctl #(.WSW(WSW), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_write(req_write), .req_io(req_io), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_dout(bus_dout),
    .bus_dout_oe(bus_dout_oe), .bus_din(bus_din), .ext_rdy(ext_rdy),
    .rw_n(rw_n), .iostrb_n(iostrb_n), .ctl_oe(ctl_oe), .msc_n(msc_n),
    .msc_oe(msc_oe), .hold_req_n(hold_req_n), .hold_gnt_n(hold_gnt_n),
    .hold_gnt_oe(hold_gnt_oe), .off_n(off_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // mode 0: ready high; 1: ready low in access cycles below lo; 2: marker looped to ready
  task automatic do_access(input int n, input bit wr, input bit io, input int mode,
                           input int lo, input bit cfg_swap);
    int exp_k;
    string tag;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    if (n < 2)          exp_k = n;
    else if (mode == 0) exp_k = n;
    else if (mode == 1) exp_k = (lo + 1 > n) ? lo + 1 : n;
    else                exp_k = n + 1;
    tag = cfg_swap ? "R10" : (n < 2) ? "R2" : (mode == 2) ? "R5" : "R3";
    a = AW'($urandom);
    d = DW'($urandom);
    step();
    cfg_wait = WSW'(n); req_valid = 1'b1; req_write = wr; req_io = io;
    req_addr = a; req_wdata = DW'($urandom); bus_din = d;
    loop_mode = (mode == 2); rdy_drv = 1'b1;
    step();
    if (cfg_swap) cfg_wait = ~WSW'(n);
    for (int k = 0; k <= exp_k; k++) begin
      if (k > 0) step();
      rdy_drv = (mode == 1) ? (k >= lo) : 1'b1;
      @(negedge clk);
      chk(tag, 32'(req_done), 32'(k == exp_k));
      chk("R4", 32'(msc_n), 32'(!(n >= 2 && k >= 1 && k <= n - 1)));
      chk("R6 rw", 32'(rw_n), 32'(!wr));
      chk("R6 io", 32'(iostrb_n), 32'(!io));
      chk("R6 doe", 32'(bus_dout_oe), 32'(wr));
      chk("R6 addr", 32'(bus_addr), 32'(a));
    end
    step();
    req_valid = 1'b0; rdy_drv = 1'b1; loop_mode = 1'b0;
    @(negedge clk);
    chk(tag, 32'(req_done), 32'd0);
    chk("R6 idle rw", 32'(rw_n), 32'd1);
    chk("R6 idle io", 32'(iostrb_n), 32'd1);
    if (!wr) chk("R7", 32'(rd_data), 32'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rw", 32'(rw_n), 32'd1);
    chk("R1 io", 32'(iostrb_n), 32'd1);
    chk("R1 msc", 32'(msc_n), 32'd1);
    chk("R1 gnt", 32'(hold_gnt_n), 32'd1);
    chk("R1 done", 32'(req_done), 32'd0);

    // R2 R3 R6 R7: every wait count, direction and space, ready high
    for (int n = 0; n < 8; n++)
      for (int t = 0; t < 4; t++)
        do_access(n, t[0], t[1], 0, 0, 0);
    // R2 R3: ready held low for lo access cycles (R2 cases must ignore it)
    for (int n = 0; n < 8; n++)
      for (int lo = 0; lo < 10; lo += 2)
        do_access(n, 1'b0, 1'b0, 1, lo, 0);
    // R5: marker fed back to ready
    for (int n = 0; n < 8; n++)
      do_access(n, n[0], 1'b0, 2, 0, 0);
    // R10: cfg changed after acceptance
    do_access(2, 1'b0, 1'b1, 0, 0, 1);
    do_access(6, 1'b1, 1'b0, 0, 0, 1);

    // R8: grant from idle, request stalled, release
    step(); hold_req_n = 1'b0;
    @(negedge clk); chk("R8 not yet", 32'(hold_gnt_n), 32'd1);
    step(); cfg_wait = '0; req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 gnt", 32'(hold_gnt_n), 32'd0);
      chk("R8 aoe", 32'(bus_addr_oe), 32'd0);
      chk("R8 doe", 32'(bus_dout_oe), 32'd0);
      chk("R8 coe", 32'(ctl_oe), 32'd0);
      chk("R8 stall", 32'(req_done), 32'd0);
      step();
    end
    hold_req_n = 1'b1;
    @(negedge clk); chk("R8 still held", 32'(hold_gnt_n), 32'd0);
    step();
    @(negedge clk); chk("R8 dropped", 32'(hold_gnt_n), 32'd1);
    chk("R8 not started", 32'(req_done), 32'd0);
    step();
    @(negedge clk); chk("R8 resumed", 32'(req_done), 32'd1);
    step(); req_valid = 1'b0;

    // R10: hold and request in the same idle cycle
    step(); hold_req_n = 1'b0; req_valid = 1'b1; cfg_wait = '0;
    @(negedge clk); chk("R10 same", 32'(req_done), 32'd0);
    step();
    @(negedge clk); chk("R10 hold wins", 32'(hold_gnt_n), 32'd0);
    chk("R10 no access", 32'(req_done), 32'd0);
    step(); req_valid = 1'b0; hold_req_n = 1'b1;
    step();
    @(negedge clk); chk("R10 release", 32'(hold_gnt_n), 32'd1);

    // R8: hold request during an access with three waits
    step(); cfg_wait = 3'd3; req_valid = 1'b1; req_write = 1'b0; req_io = 1'b0;
    step(); hold_req_n = 1'b0;
    for (int k = 0; k <= 3; k++) begin
      if (k > 0) step();
      @(negedge clk);
      chk("R8 deferred", 32'(hold_gnt_n), 32'd1);
      chk("R8 acc done", 32'(req_done), 32'(k == 3));
    end
    step(); req_valid = 1'b0;
    @(negedge clk); chk("R8 idle gap", 32'(hold_gnt_n), 32'd1);
    step();
    @(negedge clk); chk("R8 after acc", 32'(hold_gnt_n), 32'd0);
    // R9: output-off while granted
    off_n = 1'b0;
    #1;
    chk("R9 coe", 32'(ctl_oe), 32'd0);
    chk("R9 moe", 32'(msc_oe), 32'd0);
    chk("R9 goe", 32'(hold_gnt_oe), 32'd0);
    step(); hold_req_n = 1'b1;
    step();
    @(negedge clk);
    chk("R9 idle coe", 32'(ctl_oe), 32'd0);
    off_n = 1'b1;
    #1;
    chk("R9 on coe", 32'(ctl_oe), 32'd1);
    chk("R9 on moe", 32'(msc_oe), 32'd1);
    chk("R9 on goe", 32'(hold_gnt_oe), 32'd1);

    repeat (2) step();
    wrap_up();
  end
endmodule